// File: doc/BRIEF.md
# Dual-Direction Cross-Clock Mailbox

This block carries single data words between two ports that run on unrelated clocks. It bypasses any bulk storage. There is one word-wide mailbox for each direction, so side A can post a word to side B and side B can post a word to side A at the same time. Each side offers a transmit stream (valid/ready) and a receive stream (valid/ready).

A transmit transfer takes place on a rising edge of the sender's clock when valid and ready are both high. The accepted word is then held, and the sender's ready stays low until the receiver has taken the word. Back-pressure is plain: while ready is low, a presented word is not accepted. The sender must keep valid high, or withdraw it, until ready returns.

On the receiving side, valid is the new-mail flag. A read is a rising edge of the receiver's clock with valid and ready both high. The read clears the flag, and after synchronization it frees the sender's mailbox. Each event crosses between the clocks as a level toggle through a chain of synchronizer flops. The stored word is never synchronized, because it is held stable for as long as the receiver can see it.

Top module: `xdom_mailbox`

## Requirements
- R1: While `rst_n` is low, and after it is released, both receive valids read low, both transmit readies read high and both receive data buses read zero, until the first transfer.
- R2: After a transmit transfer, the receiving side's valid stays low for the first SYNC_STAGES-1 receiving-clock edges and is high after edge SYNC_STAGES. With coincident clocks and the default of 2, this is after the second edge that follows the accepting edge.
- R3: While the receive valid is high, the receive data equals the accepted word and does not change. This holds for as long as the word is left unread.
- R4: The transmit ready is low from the edge that follows an accepted transfer until the read acknowledgement returns. A word presented while ready is low is never accepted: the word held for the receiver is unchanged, and no second mail appears afterwards.
- R5: A read (receive valid and receive ready high at a receiving-clock edge) clears the receive valid at that edge. The receive data reads zero whenever the receive valid is low.
- R6: After a read, the sender's ready stays low for SYNC_STAGES-1 sender-clock edges and is high after edge SYNC_STAGES.
- R7: A receive ready asserted while no mail is held has no effect. The receive valid stays low and the sender's ready stays high.
- R8: The B-to-A mailbox behaves the same as the A-to-B one, and transfers in both directions may start on the same edge without affecting each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Side A clock |
| clk_b | input | 1 | Side B clock |
| rst_n | input | 1 | Asynchronous active-low reset; release synchronized per side |
| a_tx_valid | input | 1 | Side A offers a word for side B |
| a_tx_data | input | DATA_W | Word from side A |
| a_tx_ready | output | 1 | Side A mailbox free |
| a_rx_valid | output | 1 | Mail from side B present |
| a_rx_data | output | DATA_W | Word from side B, zero when no mail |
| a_rx_ready | input | 1 | Side A takes the mail |
| b_tx_valid | input | 1 | Side B offers a word for side A |
| b_tx_data | input | DATA_W | Word from side B |
| b_tx_ready | output | 1 | Side B mailbox free |
| b_rx_valid | output | 1 | Mail from side A present |
| b_rx_data | output | DATA_W | Word from side A, zero when no mail |
| b_rx_ready | input | 1 | Side B takes the mail |

## Verification
The bench builds the block with its defaults: DATA_W of 36 and SYNC_STAGES of 2. Both sides are driven from one coincident clock. With that clock, the two-edge flag latency and the two-edge ready recovery fall on exact, predictable cycles, so both can be checked on the exact cycle and not merely "eventually". The 36-bit width lets the test words use the top bits, which checks that every bit of the held word crosses unchanged.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned MBX_DATA_W_DEF = 36;
  localparam int unsigned MBX_SYNC_DEF   = 2;

  typedef enum logic {
    MBX_A_TO_B = 1'b0,
    MBX_B_TO_A = 1'b1
  } mbx_dir_e;
endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  localparam int unsigned N = (STAGES < 2) ? 2 : STAGES;

  logic [N-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[N-2:0], d};
  end

  assign q = chain[N-1];
endmodule

// File: rtl/mbx_channel.sv
module mbx_channel #(
  parameter int unsigned DATA_W      = 36,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_s,
  input  logic              rst_s_n,
  input  logic              s_valid,
  input  logic [DATA_W-1:0] s_data,
  output logic              s_ready,
  input  logic              clk_r,
  input  logic              rst_r_n,
  output logic              r_valid,
  output logic [DATA_W-1:0] r_data,
  input  logic              r_ready
);
  logic              req_tog_s;
  logic              ack_seen_s;
  logic [DATA_W-1:0] held_q;
  logic              req_seen_r;
  logic              ack_tog_r;
  logic              take_s;
  logic              take_r;

  // sender domain: capture word, flip request level
  assign s_ready = ~(req_tog_s ^ ack_seen_s);
  assign take_s  = s_valid & s_ready;

  always_ff @(posedge clk_s or negedge rst_s_n) begin
    if (!rst_s_n) begin
      req_tog_s <= 1'b0;
      held_q    <= '0;
    end else if (take_s) begin
      req_tog_s <= ~req_tog_s;
      held_q    <= s_data;
    end
  end

  mbx_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk   (clk_s),
    .rst_n (rst_s_n),
    .d     (ack_tog_r),
    .q     (ack_seen_s)
  );

  // receiver domain: flag while request level differs from ack level
  mbx_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk   (clk_r),
    .rst_n (rst_r_n),
    .d     (req_tog_s),
    .q     (req_seen_r)
  );

  assign r_valid = req_seen_r ^ ack_tog_r;
  assign take_r  = r_valid & r_ready;
  assign r_data  = r_valid ? held_q : '0;

  always_ff @(posedge clk_r or negedge rst_r_n) begin
    if (!rst_r_n)    ack_tog_r <= 1'b0;
    else if (take_r) ack_tog_r <= ~ack_tog_r;
  end
endmodule

// File: rtl/xdom_mailbox.sv
module xdom_mailbox
  import mbx_pkg::*;
#(
  parameter int unsigned DATA_W      = MBX_DATA_W_DEF,
  parameter int unsigned SYNC_STAGES = MBX_SYNC_DEF
) (
  input  logic              clk_a,
  input  logic              clk_b,
  input  logic              rst_n,
  input  logic              a_tx_valid,
  input  logic [DATA_W-1:0] a_tx_data,
  output logic              a_tx_ready,
  output logic              a_rx_valid,
  output logic [DATA_W-1:0] a_rx_data,
  input  logic              a_rx_ready,
  input  logic              b_tx_valid,
  input  logic [DATA_W-1:0] b_tx_data,
  output logic              b_tx_ready,
  output logic              b_rx_valid,
  output logic [DATA_W-1:0] b_rx_data,
  input  logic              b_rx_ready
);
  localparam int unsigned NDIR = 2;

  logic rst_a_n;
  logic rst_b_n;

  // assert asynchronously, release on each side's own clock
  mbx_sync #(.STAGES(SYNC_STAGES)) u_rst_a (
    .clk (clk_a), .rst_n (rst_n), .d (1'b1), .q (rst_a_n)
  );
  mbx_sync #(.STAGES(SYNC_STAGES)) u_rst_b (
    .clk (clk_b), .rst_n (rst_n), .d (1'b1), .q (rst_b_n)
  );

  logic [NDIR-1:0]             clk_s_v, clk_r_v, rst_s_v, rst_r_v;
  logic [NDIR-1:0]             s_valid_v, s_ready_v, r_valid_v, r_ready_v;
  logic [NDIR-1:0][DATA_W-1:0] s_data_v, r_data_v;

  assign clk_s_v   = {clk_b, clk_a};
  assign clk_r_v   = {clk_a, clk_b};
  assign rst_s_v   = {rst_b_n, rst_a_n};
  assign rst_r_v   = {rst_a_n, rst_b_n};
  assign s_valid_v = {b_tx_valid, a_tx_valid};
  assign s_data_v  = {b_tx_data, a_tx_data};
  assign r_ready_v = {a_rx_ready, b_rx_ready};

  for (genvar i = 0; i < NDIR; i++) begin : g_dir
    mbx_channel #(
      .DATA_W      (DATA_W),
      .SYNC_STAGES (SYNC_STAGES)
    ) u_chan (
      .clk_s   (clk_s_v[i]),
      .rst_s_n (rst_s_v[i]),
      .s_valid (s_valid_v[i]),
      .s_data  (s_data_v[i]),
      .s_ready (s_ready_v[i]),
      .clk_r   (clk_r_v[i]),
      .rst_r_n (rst_r_v[i]),
      .r_valid (r_valid_v[i]),
      .r_data  (r_data_v[i]),
      .r_ready (r_ready_v[i])
    );
  end

  assign a_tx_ready = s_ready_v[MBX_A_TO_B];
  assign b_tx_ready = s_ready_v[MBX_B_TO_A];
  assign b_rx_valid = r_valid_v[MBX_A_TO_B];
  assign b_rx_data  = r_data_v[MBX_A_TO_B];
  assign a_rx_valid = r_valid_v[MBX_B_TO_A];
  assign a_rx_data  = r_data_v[MBX_B_TO_A];
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker #(
  parameter int unsigned DATA_W = 36
) (
  input logic              clk_a,
  input logic              clk_b,
  input logic              rst_n,
  input logic              a_tx_valid,
  input logic              a_tx_ready,
  input logic              a_rx_valid,
  input logic [DATA_W-1:0] a_rx_data,
  input logic              a_rx_ready,
  input logic              b_tx_valid,
  input logic              b_tx_ready,
  input logic              b_rx_valid,
  input logic [DATA_W-1:0] b_rx_data,
  input logic              b_rx_ready
);
  assert_rx_hold_R3: assert property (@(posedge clk_b) disable iff (!rst_n)
    (b_rx_valid && $past(b_rx_valid)) |-> $stable(b_rx_data));

  assert_busy_after_accept_R4: assert property (@(posedge clk_a) disable iff (!rst_n)
    (a_tx_valid && a_tx_ready) |=> !a_tx_ready);

  assert_mail_implies_busy_R4: assert property (@(posedge clk_b) disable iff (!rst_n)
    b_rx_valid |-> !a_tx_ready);

  assert_read_clears_R5: assert property (@(posedge clk_b) disable iff (!rst_n)
    (b_rx_valid && b_rx_ready) |=> !b_rx_valid);

  assert_reverse_hold_R8: assert property (@(posedge clk_a) disable iff (!rst_n)
    (a_rx_valid && $past(a_rx_valid)) |-> $stable(a_rx_data));

  assert_reverse_busy_R8: assert property (@(posedge clk_b) disable iff (!rst_n)
    (b_tx_valid && b_tx_ready) |=> !b_tx_ready);

  assert_reverse_clears_R8: assert property (@(posedge clk_a) disable iff (!rst_n)
    (a_rx_valid && a_rx_ready) |=> !a_rx_valid);
endmodule

bind xdom_mailbox mbx_checker #(.DATA_W(DATA_W)) u_mbx_checker (
  .clk_a      (clk_a),
  .clk_b      (clk_b),
  .rst_n      (rst_n),
  .a_tx_valid (a_tx_valid),
  .a_tx_ready (a_tx_ready),
  .a_rx_valid (a_rx_valid),
  .a_rx_data  (a_rx_data),
  .a_rx_ready (a_rx_ready),
  .b_tx_valid (b_tx_valid),
  .b_tx_ready (b_tx_ready),
  .b_rx_valid (b_rx_valid),
  .b_rx_data  (b_rx_data),
  .b_rx_ready (b_rx_ready)
);

// File: tb/xdom_mailbox_tb.sv
`timescale 1ns/1ps
module xdom_mailbox_tb;
  localparam int unsigned W = 36;
  localparam int NVEC = 6;
  // bit 36: direction (0 = A to B, 1 = B to A); bits 35:0: word
  localparam logic [W:0] VEC [NVEC] = '{
    {1'b0, 36'h0_0000_0001},
    {1'b0, 36'hF_FFFF_FFFF},
    {1'b1, 36'hA_5A5A_5A5A},
    {1'b1, 36'h8_0000_0000},
    {1'b0, 36'h5_A5A5_A5A5},
    {1'b1, 36'h1_2345_6789}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_tx_valid = 1'b0, a_rx_ready = 1'b0, b_tx_valid = 1'b0, b_rx_ready = 1'b0;
  logic [W-1:0] a_tx_data = '0, b_tx_data = '0;
  logic a_tx_ready, a_rx_valid, b_tx_ready, b_rx_valid;
  logic [W-1:0] a_rx_data, b_rx_data;
  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  xdom_mailbox #(.DATA_W(W), .SYNC_STAGES(2)) u_dut (
    .clk_a (clk), .clk_b (clk), .rst_n (rst_n),
    .a_tx_valid (a_tx_valid), .a_tx_data (a_tx_data), .a_tx_ready (a_tx_ready),
    .a_rx_valid (a_rx_valid), .a_rx_data (a_rx_data), .a_rx_ready (a_rx_ready),
    .b_tx_valid (b_tx_valid), .b_tx_data (b_tx_data), .b_tx_ready (b_tx_ready),
    .b_rx_valid (b_rx_valid), .b_rx_data (b_rx_data), .b_rx_ready (b_rx_ready)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  function automatic logic tx_rdy(input bit d);
    return d ? b_tx_ready : a_tx_ready;
  endfunction
  function automatic logic rx_vld(input bit d);
    return d ? a_rx_valid : b_rx_valid;
  endfunction
  function automatic logic [W-1:0] rx_dat(input bit d);
    return d ? a_rx_data : b_rx_data;
  endfunction

  task automatic set_tx(input bit d, input logic v, input logic [W-1:0] x);
    if (d) begin b_tx_valid = v; b_tx_data = x; end
    else   begin a_tx_valid = v; a_tx_data = x; end
  endtask
  task automatic set_rd(input bit d, input logic v);
    if (d) a_rx_ready = v;
    else   b_rx_ready = v;
  endtask

  task automatic xfer(input bit d, input logic [W-1:0] x);
    @(negedge clk);
    chk(tx_rdy(d) == 1'b1, "R4 ready before send", tx_rdy(d), 1);
    set_tx(d, 1'b1, x);
    @(negedge clk);
    set_tx(d, 1'b0, '0);
    chk(tx_rdy(d) == 1'b0, "R4 busy after accept", tx_rdy(d), 0);
    chk(rx_vld(d) == 1'b0, "R2 not early (edge 0)", rx_vld(d), 0);
    @(negedge clk);
    chk(rx_vld(d) == 1'b0, "R2 not early (edge 1)", rx_vld(d), 0);
    @(negedge clk);
    chk(rx_vld(d) == 1'b1, "R2 flag after edge 2", rx_vld(d), 1);
    chk(rx_dat(d) == x, "R3 word delivered", rx_dat(d), x);
    set_rd(d, 1'b1);
    @(negedge clk);
    set_rd(d, 1'b0);
    chk(rx_vld(d) == 1'b0, "R5 read clears flag", rx_vld(d), 0);
    chk(rx_dat(d) == '0, "R5 data zero when empty", rx_dat(d), 0);
    chk(tx_rdy(d) == 1'b0, "R6 still busy (edge 0)", tx_rdy(d), 0);
    @(negedge clk);
    chk(tx_rdy(d) == 1'b0, "R6 still busy (edge 1)", tx_rdy(d), 0);
    @(negedge clk);
    chk(tx_rdy(d) == 1'b1, "R6 ready after edge 2", tx_rdy(d), 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state, during and after reset
    repeat (3) @(negedge clk);
    chk(a_tx_ready && b_tx_ready, "R1 ready in reset", {a_tx_ready, b_tx_ready}, 2'b11);
    chk(!a_rx_valid && !b_rx_valid, "R1 no mail in reset", {a_rx_valid, b_rx_valid}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(a_tx_ready && b_tx_ready, "R1 ready after reset", {a_tx_ready, b_tx_ready}, 2'b11);
    chk(!a_rx_valid && !b_rx_valid, "R1 no mail after reset", {a_rx_valid, b_rx_valid}, 0);
    chk(a_rx_data == '0 && b_rx_data == '0, "R1 data zero", a_rx_data | b_rx_data, 0);

    // vector table: both directions (B to A entries cover R8)
    for (int i = 0; i < NVEC; i++) xfer(VEC[i][W], VEC[i][W-1:0]);

    // R4: a word offered while busy is not taken
    @(negedge clk);
    set_tx(1'b0, 1'b1, 36'h1_1111_1111);
    @(negedge clk);
    set_tx(1'b0, 1'b1, 36'h2_2222_2222);
    @(negedge clk);
    @(negedge clk);
    chk(b_rx_valid == 1'b1, "R4 first word flagged", b_rx_valid, 1);
    chk(b_rx_data == 36'h1_1111_1111, "R4 held word unchanged", b_rx_data, 36'h1_1111_1111);
    set_tx(1'b0, 1'b0, '0);
    @(negedge clk);
    chk(b_rx_data == 36'h1_1111_1111, "R4 held word after drop", b_rx_data, 36'h1_1111_1111);
    b_rx_ready = 1'b1;
    @(negedge clk);
    b_rx_ready = 1'b0;
    repeat (5) @(negedge clk);
    chk(b_rx_valid == 1'b0, "R4 no second mail", b_rx_valid, 0);
    chk(a_tx_ready == 1'b1, "R4 ready back", a_tx_ready, 1);

    // R7: receive ready with no mail has no effect
    b_rx_ready = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(b_rx_valid == 1'b0, "R7 no mail appears", b_rx_valid, 0);
      chk(a_tx_ready == 1'b1, "R7 sender stays free", a_tx_ready, 1);
    end
    b_rx_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk(a_tx_ready == 1'b1, "R7 sender free after idle reads", a_tx_ready, 1);

    // R3: unread mail is held stable for a long time
    @(negedge clk);
    set_tx(1'b0, 1'b1, 36'hC_0FFE_E123);
    @(negedge clk);
    set_tx(1'b0, 1'b0, '0);
    @(negedge clk);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      chk(b_rx_valid && b_rx_data == 36'hC_0FFE_E123, "R3 word held unread", b_rx_data, 36'hC_0FFE_E123);
    end
    b_rx_ready = 1'b1;
    @(negedge clk);
    b_rx_ready = 1'b0;
    repeat (3) @(negedge clk);

    // R8: both directions start on the same edge
    @(negedge clk);
    set_tx(1'b0, 1'b1, 36'h3_3333_0000);
    set_tx(1'b1, 1'b1, 36'h0_0000_4444);
    @(negedge clk);
    set_tx(1'b0, 1'b0, '0);
    set_tx(1'b1, 1'b0, '0);
    @(negedge clk);
    @(negedge clk);
    chk(b_rx_valid && b_rx_data == 36'h3_3333_0000, "R8 A to B concurrent", b_rx_data, 36'h3_3333_0000);
    chk(a_rx_valid && a_rx_data == 36'h0_0000_4444, "R8 B to A concurrent", a_rx_data, 36'h0_0000_4444);
    a_rx_ready = 1'b1;
    @(negedge clk);
    a_rx_ready = 1'b0;
    chk(a_rx_valid == 1'b0 && b_rx_valid == 1'b1, "R8 reading one leaves other", {a_rx_valid, b_rx_valid}, 2'b01);
    b_rx_ready = 1'b1;
    @(negedge clk);
    b_rx_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk(a_tx_ready && b_tx_ready, "R8 both free again", {a_tx_ready, b_tx_ready}, 2'b11);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule